// File: doc/BRIEF.md
# Two-Phase CCD Transfer and Readout Sequencer

This block produces the digital drive pattern for a linear CCD imager that has a two-phase horizontal shift register, a transfer gate, a photo gate and an output reset gate. It runs from a fast system clock, and every interval it generates is counted in ticks of that clock. Each line starts with a parallel transfer. Horizontal clocking is parked with phase 1 high and phase 2 low. The transfer gate then opens, and the photo gate is pulsed inside the window where the transfer gate is open. The transfer gate closes after the photo gate has dropped. After the transfer, the block shifts out a fixed number of pixels. During this readout the horizontal phases are complementary, and the reset gate pulses once per pixel.

A downstream converter gets a one-tick sample strobe at a fixed delay after each phase-1 falling edge. Framing logic gets a one-tick line-start marker on the first readout tick. A single line is launched by a start pulse while the block is idle. With the free-run level held high, lines repeat back to back. The pixels per line are the isolation, dark, transition and active cells added together, and all of these counts are parameters.

Top module: `ccd_seq_top`

## Requirements
- R1: After reset, and while idle, phase 1 is high, phase 2 is low, and the transfer gate, photo gate, reset gate, sample strobe and line-start marker are all low. The block stays idle until it samples startLine or freeRun high.
- R2: When the idle block samples a go condition at a clock edge, the horizontal clocks stay parked (phase 1 high, phase 2 low) for SETUP_TICKS ticks starting at the next tick. The transfer gate rises 1+SETUP_TICKS ticks after that edge.
- R3: The transfer gate rises only while the phases are parked, and it stays high TG_LEAD_TICKS ticks before the photo gate rises.
- R4: The photo gate is high for exactly PG_HOLD_TICKS ticks, which must be at least MIN_PG_TICKS, and it is high only while the transfer gate is high.
- R5: The transfer gate falls exactly TG_TAIL_TICKS ticks after the photo gate falls.
- R6: During readout, each pixel lasts 2*HALF_TICKS ticks, which must be at least MIN_PIX_TICKS. Phase 1 is high for the first HALF_TICKS ticks of the pixel, and phase 2 is always its complement. A line has 3 + 2*10 + 2*2 + ACTIVE_PIX pixels by default.
- R7: The reset gate is high for the first RST_TICKS ticks of each pixel (RST_TICKS < HALF_TICKS), and it is low in the tick before and the tick of every phase-1 fall.
- R8: The sample strobe is high for one tick, SMP_DLY ticks after each phase-1 falling tick (1 <= SMP_DLY < HALF_TICKS), once per pixel.
- R9: The line-start marker is high for exactly one tick, the first readout tick, which directly follows the last tick of the transfer gate.
- R10: With freeRun high at the last readout tick, the next transfer begins on the following tick, so line starts are SETUP_TICKS+TG_LEAD_TICKS+PG_HOLD_TICKS+TG_TAIL_TICKS+NPIX*2*HALF_TICKS ticks apart.
- R11: startLine has no effect while a line is in progress. With freeRun low, the block returns to idle after the last readout tick and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLine | input | 1 | Launches one line when sampled high while idle |
| freeRun | input | 1 | Repeat lines back to back while high |
| phi1 | output | 1 | Horizontal phase 1 |
| phi2 | output | 1 | Horizontal phase 2 |
| tgate | output | 1 | Transfer gate |
| pgate | output | 1 | Photo gate |
| rgate | output | 1 | Output reset gate |
| sampleStb | output | 1 | One-tick video sample strobe |
| lineStart | output | 1 | One-tick first-readout-tick marker |

## Verification
The hardest situation to reach is the seam at the last readout tick. There the control must choose between an immediate new transfer and idle, using only freeRun, while a stray startLine has to be ignored. The stimulus raises startLine in the middle of a line with freeRun low. It then runs two free-run lines and drops freeRun during the second one. This exercises both decisions at the seam and the pixel-counter wrap directly into a new transfer. A per-tick queue model in the bench is compared with every output on every clock.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_TGLEAD,
    ST_PGHOLD,
    ST_TGTAIL,
    ST_READ
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic readout;
    logic tgOn;
    logic pgOn;
  } seqStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int SETUP_TICKS   = 2,
  parameter int TG_LEAD_TICKS = 2,
  parameter int PG_HOLD_TICKS = 20,
  parameter int TG_TAIL_TICKS = 2,
  parameter int TW            = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startLine,
  input  logic          freeRun,
  input  logic [TW-1:0] timer,
  input  logic          lineDone,
  output seqStrobe_t    strb
);

  localparam logic [TW-1:0] SetupEnd = TW'(SETUP_TICKS - 1);
  localparam logic [TW-1:0] LeadEnd  = TW'(TG_LEAD_TICKS - 1);
  localparam logic [TW-1:0] HoldEnd  = TW'(PG_HOLD_TICKS - 1);
  localparam logic [TW-1:0] TailEnd  = TW'(TG_TAIL_TICKS - 1);

  seqState_e state, stateNxt;
  logic      phaseEnd;

  always_comb begin
    stateNxt = state;
    phaseEnd = 1'b0;
    unique case (state)
      ST_IDLE: if (startLine || freeRun) begin
        stateNxt = ST_SETUP;
        phaseEnd = 1'b1;
      end
      ST_SETUP: if (timer == SetupEnd) begin
        stateNxt = ST_TGLEAD;
        phaseEnd = 1'b1;
      end
      ST_TGLEAD: if (timer == LeadEnd) begin
        stateNxt = ST_PGHOLD;
        phaseEnd = 1'b1;
      end
      ST_PGHOLD: if (timer == HoldEnd) begin
        stateNxt = ST_TGTAIL;
        phaseEnd = 1'b1;
      end
      ST_TGTAIL: if (timer == TailEnd) begin
        stateNxt = ST_READ;
        phaseEnd = 1'b1;
      end
      ST_READ: if (lineDone) begin
        stateNxt = freeRun ? ST_SETUP : ST_IDLE;
        phaseEnd = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.clrTimer = phaseEnd || (state == ST_IDLE);
    strb.readout  = (state == ST_READ);
    strb.tgOn     = (state == ST_TGLEAD) || (state == ST_PGHOLD) || (state == ST_TGTAIL);
    strb.pgOn     = (state == ST_PGHOLD);
  end

endmodule

// File: rtl/ccd_seq_dp.sv
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int HALF_TICKS = 3,
  parameter int RST_TICKS  = 1,
  parameter int SMP_DLY    = 1,
  parameter int NPIX       = 539,
  parameter int TW         = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  output logic [TW-1:0] timer,
  output logic          lineDone,
  output logic          phi1,
  output logic          phi2,
  output logic          tgate,
  output logic          pgate,
  output logic          rgate,
  output logic          sampleStb,
  output logic          lineStart
);

  localparam int PIX_TICKS = 2 * HALF_TICKS;
  localparam int PW = (PIX_TICKS > 1) ? $clog2(PIX_TICKS) : 1;
  localparam int XW = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam logic [PW-1:0] PhLast  = PW'(PIX_TICKS - 1);
  localparam logic [PW-1:0] PhHalf  = PW'(HALF_TICKS);
  localparam logic [PW-1:0] PhRst   = PW'(RST_TICKS);
  localparam logic [PW-1:0] PhSmp   = PW'(HALF_TICKS + SMP_DLY);
  localparam logic [XW-1:0] PixLast = XW'(NPIX - 1);

  logic [PW-1:0] phase;
  logic [XW-1:0] pixIdx;

  // Interval timer shared by all transfer phases
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) timer <= '0;
    else                        timer <= timer + 1'b1;
  end

  // Phase-in-pixel and pixel index
  always_ff @(posedge clk) begin
    if (!rstN || !strb.readout) begin
      phase  <= '0;
      pixIdx <= '0;
    end else if (phase == PhLast) begin
      phase  <= '0;
      pixIdx <= (pixIdx == PixLast) ? '0 : pixIdx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    lineDone  = strb.readout && (phase == PhLast) && (pixIdx == PixLast);
    phi1      = strb.readout ? (phase < PhHalf) : 1'b1;
    phi2      = strb.readout && (phase >= PhHalf);
    rgate     = strb.readout && (phase < PhRst);
    sampleStb = strb.readout && (phase == PhSmp);
    lineStart = strb.readout && (phase == '0) && (pixIdx == '0);
    tgate     = strb.tgOn;
    pgate     = strb.pgOn;
  end

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int ACTIVE_PIX    = 512,
  parameter int ISO_PIX       = 3,
  parameter int DARK_PIX      = 10,
  parameter int TRANS_PIX     = 2,
  parameter int HALF_TICKS    = 3,
  parameter int RST_TICKS     = 1,
  parameter int SMP_DLY       = 1,
  parameter int SETUP_TICKS   = 2,
  parameter int TG_LEAD_TICKS = 2,
  parameter int PG_HOLD_TICKS = 20,
  parameter int TG_TAIL_TICKS = 2,
  parameter int MIN_PG_TICKS  = 20,
  parameter int MIN_PIX_TICKS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic startLine,
  input  logic freeRun,
  output logic phi1,
  output logic phi2,
  output logic tgate,
  output logic pgate,
  output logic rgate,
  output logic sampleStb,
  output logic lineStart
);

  localparam int NPIX   = ISO_PIX + 2 * DARK_PIX + 2 * TRANS_PIX + ACTIVE_PIX;
  localparam int MAX_IV = maxOf4(SETUP_TICKS, TG_LEAD_TICKS, PG_HOLD_TICKS, TG_TAIL_TICKS);
  localparam int TW     = $clog2(MAX_IV + 1) + 1;

  seqStrobe_t    strb;
  logic [TW-1:0] timer;
  logic          lineDone;

  ccd_seq_ctrl #(
    .SETUP_TICKS(SETUP_TICKS), .TG_LEAD_TICKS(TG_LEAD_TICKS),
    .PG_HOLD_TICKS(PG_HOLD_TICKS), .TG_TAIL_TICKS(TG_TAIL_TICKS), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startLine(startLine), .freeRun(freeRun),
    .timer(timer), .lineDone(lineDone), .strb(strb)
  );

  ccd_seq_dp #(
    .HALF_TICKS(HALF_TICKS), .RST_TICKS(RST_TICKS), .SMP_DLY(SMP_DLY),
    .NPIX(NPIX), .TW(TW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timer(timer), .lineDone(lineDone),
    .phi1(phi1), .phi2(phi2), .tgate(tgate), .pgate(pgate), .rgate(rgate),
    .sampleStb(sampleStb), .lineStart(lineStart)
  );

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk #(
  parameter int SMP_DLY       = 1,
  parameter int MIN_PG_TICKS  = 20,
  parameter int MIN_PIX_TICKS = 5
) (
  input logic clk,
  input logic rstN,
  input logic phi1,
  input logic phi2,
  input logic tgate,
  input logic pgate,
  input logic rgate,
  input logic sampleStb,
  input logic lineStart
);

  logic        prevPhi1;
  logic [15:0] pgRun;
  logic [15:0] sinceRise;
  logic [15:0] sinceFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPhi1  <= 1'b1;
      pgRun     <= '0;
      sinceRise <= '0;
      sinceFall <= '0;
    end else begin
      prevPhi1 <= phi1;
      pgRun    <= pgate ? ((pgRun == 16'hFFFF) ? pgRun : pgRun + 1'b1) : '0;
      if (!prevPhi1 && phi1)       sinceRise <= 16'd1;
      else if (sinceRise != 16'hFFFF) sinceRise <= sinceRise + 1'b1;
      if (prevPhi1 && !phi1)       sinceFall <= 16'd1;
      else if (sinceFall != 16'hFFFF) sinceFall <= sinceFall + 1'b1;
    end
  end

  a_r6_complementary: assert property (@(posedge clk) disable iff (!rstN)
    phi1 != phi2);

  a_r3_tg_rise_parked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgate) |-> (phi1 && !phi2 && $past(phi1) && !$past(phi2)));

  a_r4_pg_inside_tg: assert property (@(posedge clk) disable iff (!rstN)
    pgate |-> tgate);

  a_r4_pg_min_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgate) |-> (pgRun >= 16'(MIN_PG_TICKS)));

  a_r5_tg_after_pg: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgate) |-> (!pgate && !$past(pgate)));

  a_r6_min_pixel_period: assert property (@(posedge clk) disable iff (!rstN)
    (!prevPhi1 && phi1) |-> (sinceRise >= 16'(MIN_PIX_TICKS)));

  a_r7_rg_low_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phi1) |-> (!rgate && !$past(rgate)));

  a_r8_sample_delay: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sinceFall == 16'(SMP_DLY)));

  a_r9_line_start_after_tg: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> (!tgate && $past(tgate)));

endmodule

bind ccd_seq_top ccd_seq_chk #(
  .SMP_DLY(SMP_DLY), .MIN_PG_TICKS(MIN_PG_TICKS), .MIN_PIX_TICKS(MIN_PIX_TICKS)
) u_chk (
  .clk(clk), .rstN(rstN), .phi1(phi1), .phi2(phi2), .tgate(tgate),
  .pgate(pgate), .rgate(rgate), .sampleStb(sampleStb), .lineStart(lineStart)
);

// File: tb/test_ccd_seq_top.sv
module test_ccd_seq_top;

  localparam int ACT   = 8;
  localparam int HALF  = 3;
  localparam int RSTW  = 1;
  localparam int SDLY  = 1;
  localparam int SETUP = 2;
  localparam int LEAD  = 2;
  localparam int HOLD  = 20;
  localparam int TAIL  = 2;
  localparam int NPIX  = 3 + 20 + 4 + ACT;
  localparam int LINE_TICKS = SETUP + LEAD + HOLD + TAIL + NPIX * 2 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startLine = 1'b0;
  logic freeRun = 1'b0;
  logic phi1, phi2, tgate, pgate, rgate, sampleStb, lineStart;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccd_seq_top #(
    .ACTIVE_PIX(ACT), .HALF_TICKS(HALF), .RST_TICKS(RSTW), .SMP_DLY(SDLY),
    .SETUP_TICKS(SETUP), .TG_LEAD_TICKS(LEAD), .PG_HOLD_TICKS(HOLD),
    .TG_TAIL_TICKS(TAIL)
  ) i_ccd_seq_top (
    .clk(clk), .rstN(rstN), .startLine(startLine), .freeRun(freeRun),
    .phi1(phi1), .phi2(phi2), .tgate(tgate), .pgate(pgate), .rgate(rgate),
    .sampleStb(sampleStb), .lineStart(lineStart)
  );

  // Vector order: {lineStart, sampleStb, rgate, pgate, tgate, phi2, phi1}
  localparam logic [6:0] IDLE_VEC = 7'b0000001;
  logic [6:0] expQ[$];

  function automatic void fillLine();
    for (int i = 0; i < SETUP; i++) expQ.push_back(IDLE_VEC);
    for (int i = 0; i < LEAD; i++)  expQ.push_back(7'b0000101);
    for (int i = 0; i < HOLD; i++)  expQ.push_back(7'b0001101);
    for (int i = 0; i < TAIL; i++)  expQ.push_back(7'b0000101);
    for (int p = 0; p < NPIX; p++) begin
      for (int t = 0; t < 2 * HALF; t++) begin
        logic [6:0] v;
        v[0] = (t < HALF);
        v[1] = !(t < HALF);
        v[2] = 1'b0;
        v[3] = 1'b0;
        v[4] = (t < RSTW);
        v[5] = (t == HALF + SDLY);
        v[6] = (p == 0) && (t == 0);
        expQ.push_back(v);
      end
    end
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) expQ.delete();
    else if (expQ.size() == 0) begin
      if (startLine || freeRun) fillLine();
    end else begin
      void'(expQ.pop_front());
      if (expQ.size() == 0 && freeRun) fillLine();
    end
  end

  function automatic string reqOf(input int b);
    case (b)
      0, 1: return "R6";
      2: return "R3";
      3: return "R4";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-tick comparison and event capture
  int tgRiseCyc = -1, tgFallCyc = -1, pgRiseCyc = -1, pgFallCyc = -1;
  int lsCyc[$];
  int smpCount = 0;
  logic prevTg = 1'b0, prevPg = 1'b0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [6:0] act, exp;
      act = {lineStart, sampleStb, rgate, pgate, tgate, phi2, phi1};
      exp = (expQ.size() != 0) ? expQ[0] : IDLE_VEC;
      tests++;
      if (act != exp) begin
        fails++;
        for (int b = 0; b < 7; b++)
          if (act[b] != exp[b])
            $display("FAIL %s cycle %0d bit %0d: actual %0b expected %0b",
                     reqOf(b), cyc, b, act, exp);
      end
      if (tgate && !prevTg) tgRiseCyc = cyc;
      if (!tgate && prevTg) tgFallCyc = cyc;
      if (pgate && !prevPg) pgRiseCyc = cyc;
      if (!pgate && prevPg) pgFallCyc = cyc;
      if (lineStart) lsCyc.push_back(cyc);
      if (sampleStb) smpCount++;
      prevTg = tgate;
      prevPg = pgate;
    end
  end

  task automatic idleCheck(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {lineStart, sampleStb, rgate, pgate, tgate, phi2, phi1}, IDLE_VEC, "idle levels");
    end
  endtask

  initial begin
    int s;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset and idle state
    @(negedge clk);
    check("R1", {lineStart, sampleStb, rgate, pgate, tgate, phi2, phi1}, IDLE_VEC, "after reset");
    idleCheck("R1", 10);

    // R2: single line launched by a start pulse
    startLine = 1'b1;
    s = cyc;
    @(negedge clk);
    startLine = 1'b0;
    repeat (SETUP + LEAD + HOLD + 20) @(negedge clk);
    check("R2", tgRiseCyc - s, 1 + SETUP, "start to transfer gate rise");
    check("R3", pgRiseCyc - tgRiseCyc, LEAD, "transfer gate lead");
    check("R4", pgFallCyc - pgRiseCyc, HOLD, "photo gate hold");
    check("R5", tgFallCyc - pgFallCyc, TAIL, "transfer gate tail");
    // R11: start in mid-line must be ignored
    startLine = 1'b1;
    @(negedge clk);
    startLine = 1'b0;
    repeat (LINE_TICKS) @(negedge clk);
    check("R8", smpCount, NPIX, "sample strobes per line");
    check("R9", lsCyc.size(), 1, "line starts for one line");
    idleCheck("R11", 20);

    // R10: back-to-back free-running lines
    lsCyc.delete();
    smpCount = 0;
    freeRun = 1'b1;
    repeat (LINE_TICKS + 10) @(negedge clk);
    freeRun = 1'b0;
    repeat (LINE_TICKS + 10) @(negedge clk);
    check("R10", lsCyc.size(), 2, "line starts in two free-run lines");
    if (lsCyc.size() == 2)
      check("R10", lsCyc[1] - lsCyc[0], LINE_TICKS, "line start spacing");
    check("R6", smpCount, 2 * NPIX, "pixels over two lines");
    idleCheck("R11", 10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule